// File: doc/BRIEF.md
# Implicit Second-Destination Selector

Some three-input instructions write two results: a main result to the named destination and a second result to a destination that the instruction word does not name. This block works out that unnamed register. It receives the instruction word, the prefix word, the already-extended destination and third-source register numbers with their scalar/vector flags, the current vector length, and a flag that says whether vector extension is active. One clock later it presents the second-destination register number, its scalar/vector flag, and a valid flag.

The valid flag rises only for the two instructions that have a second destination. There are three rules for choosing the register:

- With vector extension off, the register is the scalar pair of the destination, which is the destination plus one.
- With vector extension on and the prefix mode bit clear, the register is the destination offset by the vector length. Its scalar/vector flag follows the destination.
- With vector extension on and the mode bit set, the register is the third source, with the same scalar/vector flag as the third source.

A decode stage uses the result to reserve and steer the second write port.

Top module: `sdst_select`

## Requirements
- R1: While rst_n is low, and in the first cycle after it rises, s2_valid, s2_num and s2_vec are all zero.
- R2: s2_valid is 1 one cycle after a cycle with in_valid=1, insn[31:26]=6'd4 (big-endian bits 0..5) and insn[5:0] (big-endian bits 26..31) equal to 6'b110010 or 6'b110100. Otherwise it is 0. All other minor codes and primary codes give 0.
- R3: Whenever s2_valid is 0, s2_num and s2_vec are 0.
- R4: With vec_on=0, a decoded instruction gives s2_num = rt_num+1 modulo 2^REG_W and s2_vec = 0.
- R5: With vec_on=1 and the mode bit clear, s2_num = rt_num+vl modulo 2^REG_W.
- R6: With vec_on=1 and the mode bit clear, s2_vec equals rt_vec.
- R7: With vec_on=1 and the mode bit set, s2_num equals rc_num and s2_vec equals rc_vec.
- R8: The mode bit is prefix bit 18 in big-endian numbering, which is prefix[13]. No other prefix bit affects the outputs.
- R9: With vec_on=0, the mode bit has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction present this cycle |
| insn | input | 32 | Instruction word, big-endian bit 0 at insn[31] |
| prefix | input | 32 | Prefix word, big-endian bit 0 at prefix[31] |
| vec_on | input | 1 | Vector extension active |
| rt_num | input | REG_W | Extended primary destination number |
| rt_vec | input | 1 | Primary destination is vector |
| rc_num | input | REG_W | Extended third-source number |
| rc_vec | input | 1 | Third source is vector |
| vl | input | REG_W | Current vector length |
| s2_valid | output | 1 | Instruction needs a second destination |
| s2_num | output | REG_W | Second destination register number |
| s2_vec | output | 1 | Second destination is vector |

## Verification
The bench builds the block with REG_W=4. This lets it sweep every combination of destination number and vector length under all four settings of vec_on and the mode bit. Every wraparound of rt_num+1 and rt_num+vl modulo 16 is therefore checked. The bench also sweeps all 64 minor codes under two primary codes, and it flips prefix bits beside the mode bit to show that they are ignored.

// File: rtl/sdst_select.sv
module sdst_select #(
  parameter int REG_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [31:0]      insn,
  input  logic [31:0]      prefix,
  input  logic             vec_on,
  input  logic [REG_W-1:0] rt_num,
  input  logic             rt_vec,
  input  logic [REG_W-1:0] rc_num,
  input  logic             rc_vec,
  input  logic [REG_W-1:0] vl,
  output logic             s2_valid,
  output logic [REG_W-1:0] s2_num,
  output logic             s2_vec
);
  localparam logic [5:0] PRI_OP  = 6'd4;
  localparam logic [5:0] XO_MADD = 6'b110010;
  localparam logic [5:0] XO_DREM = 6'b110100;

  logic [5:0] pri, xo;
  logic       hit, mode_rc;
  logic [REG_W-1:0] addend, sum, nxt_num;
  logic       nxt_vec;
  logic       started;

  assign pri     = insn[31:26];
  assign xo      = insn[5:0];
  assign mode_rc = prefix[31-18];
  assign hit     = in_valid && pri == PRI_OP && (xo == XO_MADD || xo == XO_DREM);

  assign addend = vec_on ? vl : REG_W'(1);
  assign sum    = rt_num + addend;

  always_comb begin
    nxt_num = '0;
    nxt_vec = 1'b0;
    if (hit) begin
      if (vec_on && mode_rc) begin
        nxt_num = rc_num;
        nxt_vec = rc_vec;
      end else begin
        nxt_num = sum;
        nxt_vec = vec_on && rt_vec;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s2_valid <= 1'b0;
      s2_num   <= '0;
      s2_vec   <= 1'b0;
      started  <= 1'b0;
    end else begin
      s2_valid <= hit;
      s2_num   <= nxt_num;
      s2_vec   <= nxt_vec;
      started  <= 1'b1;
    end
  end

  p_reset_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !started |-> (!s2_valid && s2_num == '0 && !s2_vec));

  p_decode_r2: assert property (@(posedge clk) disable iff (!rst_n)
    started |-> (s2_valid == ($past(in_valid) && $past(insn[31:26]) == 6'd4 &&
      ($past(insn[5:0]) == 6'b110010 || $past(insn[5:0]) == 6'b110100))));

  p_idle_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !s2_valid |-> (s2_num == '0 && !s2_vec));

  p_scalar_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (started && s2_valid && !$past(vec_on)) |->
      (s2_num == REG_W'($past(rt_num) + 1'b1) && !s2_vec));

  p_vl_offset_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (started && s2_valid && $past(vec_on) && !$past(prefix[13])) |->
      (s2_num == REG_W'($past(rt_num) + $past(vl)) && s2_vec == $past(rt_vec)));

  p_alias_rc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (started && s2_valid && $past(vec_on) && $past(prefix[13])) |->
      (s2_num == $past(rc_num) && s2_vec == $past(rc_vec)));
endmodule

// File: tb/sdst_select_tb_top.sv
module sdst_select_tb_top;
  localparam int W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [31:0] insn = '0, prefix = '0;
  logic vec_on = 1'b0, rt_vec = 1'b0, rc_vec = 1'b0;
  logic [W-1:0] rt_num = '0, rc_num = '0, vl = '0;
  logic s2_valid, s2_vec;
  logic [W-1:0] s2_num;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sdst_select #(.REG_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .insn(insn), .prefix(prefix),
    .vec_on(vec_on), .rt_num(rt_num), .rt_vec(rt_vec), .rc_num(rc_num),
    .rc_vec(rc_vec), .vl(vl), .s2_valid(s2_valid), .s2_num(s2_num), .s2_vec(s2_vec));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_insn(input logic [5:0] p, input logic [5:0] x);
    return {p, 20'h5A3C1, x};
  endfunction

  task automatic run_one(input logic [5:0] p, input logic [5:0] x, input logic [31:0] pf,
                         input logic von, input logic [W-1:0] rt, input logic rtv,
                         input logic [W-1:0] rc, input logic rcv, input logic [W-1:0] l);
    logic exp_v, exp_vec, md;
    logic [W-1:0] exp_n;
    @(negedge clk);
    in_valid = 1'b1; insn = mk_insn(p, x); prefix = pf; vec_on = von;
    rt_num = rt; rt_vec = rtv; rc_num = rc; rc_vec = rcv; vl = l;
    md = pf[13];
    exp_v = (p == 6'd4) && (x == 6'b110010 || x == 6'b110100);
    exp_n = '0; exp_vec = 1'b0;
    if (exp_v) begin
      if (!von) exp_n = W'(rt + 1);
      else if (!md) begin exp_n = W'(rt + l); exp_vec = rtv; end
      else begin exp_n = rc; exp_vec = rcv; end
    end
    @(negedge clk);
    chk("R2 valid", {31'b0, s2_valid}, {31'b0, exp_v});
    if (!exp_v) begin
      chk("R3 num", {28'b0, s2_num}, 32'd0);
      chk("R3 vec", {31'b0, s2_vec}, 32'd0);
    end else if (!von) begin
      chk(md ? "R9 num" : "R4 num", {28'b0, s2_num}, {28'b0, exp_n});
      chk("R4 vec", {31'b0, s2_vec}, {31'b0, exp_vec});
    end else if (!md) begin
      chk("R5 num", {28'b0, s2_num}, {28'b0, exp_n});
      chk("R6 vec", {31'b0, s2_vec}, {31'b0, exp_vec});
    end else begin
      chk("R7 num", {28'b0, s2_num}, {28'b0, exp_n});
      chk("R7 vec", {31'b0, s2_vec}, {31'b0, exp_vec});
    end
    in_valid = 1'b0;
  endtask

  initial begin
    in_valid = 1'b1; insn = mk_insn(6'd4, 6'b110010); vec_on = 1'b1; rt_num = 4'd3; vl = 4'd2;
    repeat (3) @(negedge clk);
    chk("R1 valid", {31'b0, s2_valid}, 32'd0);
    chk("R1 num", {28'b0, s2_num}, 32'd0);
    chk("R1 vec", {31'b0, s2_vec}, 32'd0);
    rst_n = 1'b1;
    in_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R1 after reset", {31'b0, s2_valid}, 32'd0);

    for (int p = 4; p <= 5; p++)
      for (int x = 0; x < 64; x++)
        run_one(6'(p), 6'(x), 32'h0, 1'b1, 4'd7, 1'b1, 4'd9, 1'b0, 4'd5);

    for (int rt = 0; rt < 16; rt++)
      for (int l = 0; l < 16; l++)
        for (int m = 0; m < 4; m++) begin
          logic [31:0] pf;
          pf = 32'hA5A5_5A5A ^ (32'(rt) << 14) ^ (32'(l) << 9);
          pf[13] = m[1];
          run_one(6'd4, (l[0] ? 6'b110100 : 6'b110010), pf, m[0], 4'(rt), rt[0] ^ l[1],
                  4'(rt * 3 + l), ~l[0], 4'(l));
        end

    // R8: flip every non-mode prefix bit, result must match the all-clear prefix
    for (int b = 0; b < 32; b++)
      if (b != 13) begin
        run_one(6'd4, 6'b110010, 32'(1) << b, 1'b1, 4'd14, 1'b1, 4'd2, 1'b0, 4'd3);
        chk("R8 num", {28'b0, s2_num}, 32'd1);
      end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual 0 expected 1");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule